// File: doc/BRIEF.md
# Symbol Pair Injector

The injector sits in a transmit path just before the multiplexer that feeds the 4B/5B line encoder. Each cycle it may receive one symbol pair: either a data pair (eight data bits) or a control pair. On a data pair it can replace the outgoing pair with a replacement pair. This replacement pair is taken from two 5-bit symbol inputs that are already in 5B code, so it skips the encoder. The block raises a select flag so that the downstream mux forwards the raw 10-bit code in place of the encoded byte.

How often a replacement happens is set by a 2-bit injection mode and a threshold. In the periodic modes, a down-counter is loaded from the threshold. Each data pair decrements the counter. A replacement happens when the counter is already at zero, and the counter then reloads. One of the periodic modes also reloads the counter whenever the frame start delimiter pair passes. In one-shot mode the next data pair is replaced, and the hardware then returns the mode to off. The host can capture a snapshot of the counter with a read strobe.

Top module: `sym_pair_injector`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `out_inj` are 0, `ctl_q` is 2'b00 and `cnt_snap` is 0.
- R2: Every input pair appears on the outputs (`out_valid`, `out_ctl`, `out_byte`) exactly one clock later. In mode 2'b00 (off), `out_inj` stays 0.
- R3: In mode 2'b10 (periodic) with threshold N, a write to the control register loads the counter with N. After that, every (N+1)-th data pair is replaced.
- R4: In a periodic mode with threshold 0, every data pair is replaced.
- R5: Only data pairs (`in_ctl`=0) are replaced. Control pairs pass through unchanged with `out_inj`=0, and they do not advance the counter.
- R6: A replaced pair has `out_inj`=1 and `out_code` = {`sym_a`,`sym_b`}, with `sym_a` in bits 9:5. The symbols are sampled in the same cycle as the data pair they replace.
- R7: In mode 2'b01 (one shot), the next data pair is replaced. `ctl_q` then reads 2'b00, and later data pairs pass through unreplaced.
- R8: In mode 2'b11, a control pair whose byte equals `JK_CODE` (default 8'hD5) reloads the counter from the threshold. In mode 2'b10 the same pair does not change the count.
- R9: A pulse on `rd_stb` copies the counter value held before that cycle's update into `cnt_snap`. The value stays there until the next pulse.
- R10: A host write in the same cycle as a one-shot replacement takes priority over the automatic clear. The replacement still happens under the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A symbol pair is present this cycle |
| in_ctl | input | 1 | 1 = control pair, 0 = data pair |
| in_byte | input | BW | Pair contents (data or control code) |
| thr | input | CW | Injection threshold |
| sym_a | input | SW | First replacement symbol, 5B coded |
| sym_b | input | SW | Second replacement symbol, 5B coded |
| ctl_wr | input | 1 | Host write strobe for the injection mode |
| ctl_wdata | input | 2 | Injection mode value to write |
| rd_stb | input | 1 | Host read strobe, captures a counter snapshot |
| out_valid | output | 1 | Output pair present |
| out_ctl | output | 1 | Output pair is a control pair |
| out_byte | output | BW | Output pair contents |
| out_inj | output | 1 | Encoder mux must take `out_code` in place of the byte |
| out_code | output | 2*SW | Replacement 5B pair, zero when not replacing |
| ctl_q | output | 2 | Current injection mode |
| cnt_snap | output | CW | Counter snapshot |

## Verification
The assertions assume that the host does not write the mode in the same cycle as a frame start delimiter pair. They also assume that the threshold is held steady while a periodic mode counts down, because the decrement checks compare the count only against its own past value. The directed stimulus writes the mode in an idle cycle (`in_valid` low) before each sequence. It changes the threshold only together with a write, and the same-cycle write case is exercised on a data pair only.

// File: rtl/sym_inj_pkg.sv
package sym_inj_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ONE   = 2'b01,
    MODE_PER   = 2'b10,
    MODE_PERJK = 2'b11
  } inj_mode_e;
endpackage

// File: rtl/sym_inj_ctrl.sv
module sym_inj_ctrl
  import sym_inj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  input  logic       is_data,
  output inj_mode_e  mode
);
  inj_mode_e mode_q, mode_d;
  logic      mode_en;

  always_comb begin
    mode_d  = mode_q;
    mode_en = 1'b0;
    if (ctl_wr) begin
      mode_d  = inj_mode_e'(ctl_wdata);
      mode_en = 1'b1;
    end else if (mode_q == MODE_ONE && is_data) begin
      mode_d  = MODE_OFF;
      mode_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode = mode_q;

  AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ONE && is_data && !ctl_wr) |=> (mode_q == MODE_OFF)); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (mode_q == $past(ctl_wdata))); // R10
endmodule

// File: rtl/sym_inj_counter.sv
module sym_inj_counter
  import sym_inj_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  inj_mode_e     mode,
  input  logic [CW-1:0] thr,
  input  logic          ctl_wr,
  input  logic          is_data,
  input  logic          is_jk,
  input  logic          rd_stb,
  output logic          fire,
  output logic [CW-1:0] cnt_snap
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] snap_q;
  logic          periodic;
  logic          at_zero;
  logic          jk_reload;

  assign periodic  = (mode == MODE_PER) || (mode == MODE_PERJK);
  assign at_zero   = (cnt_q == '0);
  assign jk_reload = (mode == MODE_PERJK) && is_jk;
  assign fire      = is_data && ((mode == MODE_ONE) || (periodic && at_zero));

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (ctl_wr) begin
      cnt_d  = thr;
      cnt_en = 1'b1;
    end else if (periodic && is_data) begin
      cnt_d  = at_zero ? thr : (cnt_q - 1'b1);
      cnt_en = 1'b1;
    end else if (jk_reload) begin
      cnt_d  = thr;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (rd_stb) snap_q <= cnt_q;
  end

  assign cnt_snap = snap_q;

  AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && is_data && !at_zero && !ctl_wr) |=> (cnt_q == CW'($past(cnt_q) - 1'b1))); // R3
  AST_NONDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_data && !ctl_wr && !jk_reload) |=> $stable(cnt_q)); // R5
  AST_JK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (jk_reload && !ctl_wr) |=> (cnt_q == $past(thr))); // R8
endmodule

// File: rtl/sym_inj_outstage.sv
module sym_inj_outstage #(
  parameter int BW = 8,
  parameter int SW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_ctl,
  input  logic [BW-1:0]  in_byte,
  input  logic           fire,
  input  logic [SW-1:0]  sym_a,
  input  logic [SW-1:0]  sym_b,
  output logic           out_valid,
  output logic           out_ctl,
  output logic [BW-1:0]  out_byte,
  output logic           out_inj,
  output logic [2*SW-1:0] out_code
);
  logic [2*SW-1:0] code_d;

  assign code_d = fire ? {sym_a, sym_b} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ctl   <= 1'b0;
      out_byte  <= '0;
      out_inj   <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      out_ctl   <= in_ctl;
      out_byte  <= in_byte;
      out_inj   <= fire;
      out_code  <= code_d;
    end
  end

  AST_INJ_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_inj |-> (out_valid && !out_ctl)); // R5
  AST_INJ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (out_code == $past({sym_a, sym_b}))); // R6
endmodule

// File: rtl/sym_pair_injector.sv
module sym_pair_injector
  import sym_inj_pkg::*;
#(
  parameter int          CW      = 8,
  parameter int          BW      = 8,
  parameter int          SW      = 5,
  parameter logic [7:0]  JK_CODE = 8'hD5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_ctl,
  input  logic [BW-1:0]   in_byte,
  input  logic [CW-1:0]   thr,
  input  logic [SW-1:0]   sym_a,
  input  logic [SW-1:0]   sym_b,
  input  logic            ctl_wr,
  input  logic [1:0]      ctl_wdata,
  input  logic            rd_stb,
  output logic            out_valid,
  output logic            out_ctl,
  output logic [BW-1:0]   out_byte,
  output logic            out_inj,
  output logic [2*SW-1:0] out_code,
  output logic [1:0]      ctl_q,
  output logic [CW-1:0]   cnt_snap
);
  localparam int RSYNC = 2;

  logic [RSYNC-1:0] rst_pipe;
  logic             rst_s_n;
  inj_mode_e        mode;
  logic             is_data;
  logic             is_jk;
  logic             fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RSYNC-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[RSYNC-1];

  assign is_data = in_valid && !in_ctl;
  assign is_jk   = in_valid && in_ctl && (in_byte == BW'(JK_CODE));

  sym_inj_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .is_data   (is_data),
    .mode      (mode)
  );

  sym_inj_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode     (mode),
    .thr      (thr),
    .ctl_wr   (ctl_wr),
    .is_data  (is_data),
    .is_jk    (is_jk),
    .rd_stb   (rd_stb),
    .fire     (fire),
    .cnt_snap (cnt_snap)
  );

  sym_inj_outstage #(.BW(BW), .SW(SW)) u_out (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_valid  (in_valid),
    .in_ctl    (in_ctl),
    .in_byte   (in_byte),
    .fire      (fire),
    .sym_a     (sym_a),
    .sym_b     (sym_b),
    .out_valid (out_valid),
    .out_ctl   (out_ctl),
    .out_byte  (out_byte),
    .out_inj   (out_inj),
    .out_code  (out_code)
  );

  assign ctl_q = mode;

  AST_OFF_NO_INJ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_OFF) |=> !out_inj); // R2
  AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_valid |=> (out_valid && out_byte == $past(in_byte))); // R2
endmodule

// File: tb/sym_pair_injector_tb.sv
module sym_pair_injector_tb_top;
  localparam logic [7:0] JK = 8'hD5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ctl, ctl_wr, rd_stb;
  logic [7:0] in_byte, thr;
  logic [4:0] sym_a, sym_b;
  logic [1:0] ctl_wdata;
  logic       out_valid, out_ctl, out_inj;
  logic [7:0] out_byte, cnt_snap;
  logic [9:0] out_code;
  logic [1:0] ctl_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sym_pair_injector #(.JK_CODE(JK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctl(in_ctl),
    .in_byte(in_byte), .thr(thr), .sym_a(sym_a), .sym_b(sym_b),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .rd_stb(rd_stb),
    .out_valid(out_valid), .out_ctl(out_ctl), .out_byte(out_byte),
    .out_inj(out_inj), .out_code(out_code), .ctl_q(ctl_q), .cnt_snap(cnt_snap)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then sample shortly after the rising edge.
  task automatic step(input bit v, input bit c, input logic [7:0] b,
                      input bit wr, input logic [1:0] wd, input bit rd);
    @(negedge clk);
    in_valid = v; in_ctl = c; in_byte = b;
    ctl_wr = wr; ctl_wdata = wd; rd_stb = rd;
    @(posedge clk);
    #2;
  endtask

  task automatic data_pair(input logic [7:0] b, input bit exp_inj, input string req);
    step(1, 0, b, 0, 2'b00, 0);
    chk({req, " byte"}, out_byte, b);
    chk({req, " inj"}, out_inj, exp_inj);
    chk({req, " code"}, out_code, exp_inj ? {sym_a, sym_b} : 10'h0);
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [7:0] t);
    @(negedge clk);
    thr = t;
    step(0, 0, 8'h00, 1, m, 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid, 0);
    chk("R1 inj", out_inj, 0);
    chk("R1 mode", ctl_q, 0);
    chk("R1 snap", cnt_snap, 0);
  endtask

  task automatic t_pass;
    sym_a = 5'h11; sym_b = 5'h0A;
    data_pair(8'h3C, 0, "R2 off data");
    step(1, 1, 8'h07, 0, 2'b00, 0);
    chk("R2 ctl flag", out_ctl, 1);
    chk("R2 ctl byte", out_byte, 8'h07);
  endtask

  task automatic t_periodic;
    sym_a = 5'h18; sym_b = 5'h11;
    set_mode(2'b10, 8'd2);
    data_pair(8'h01, 0, "R3 p1");
    step(0, 0, 8'h00, 0, 2'b00, 1);
    step(0, 0, 8'h00, 0, 2'b00, 0);
    chk("R9 snapshot", cnt_snap, 1);
    step(1, 1, 8'h42, 0, 2'b00, 0);
    chk("R5 ctl pass inj", out_inj, 0);
    chk("R5 ctl pass byte", out_byte, 8'h42);
    data_pair(8'h02, 0, "R5 p2 no decrement by ctl");
    data_pair(8'h03, 1, "R3 p3 inject");
    sym_a = 5'h07; sym_b = 5'h1D;
    data_pair(8'h04, 0, "R3 p4");
    data_pair(8'h05, 0, "R3 p5");
    data_pair(8'h06, 1, "R6 p6 inject new symbols");
    chk("R9 snapshot held", cnt_snap, 1);
  endtask

  task automatic t_thr0;
    sym_a = 5'h13; sym_b = 5'h0E;
    set_mode(2'b10, 8'd0);
    for (int i = 0; i < 3; i++) data_pair(8'h10 + 8'(i), 1, "R4 every pair");
  endtask

  task automatic t_oneshot;
    sym_a = 5'h19; sym_b = 5'h0B;
    set_mode(2'b01, 8'd5);
    chk("R7 mode set", ctl_q, 1);
    step(1, 1, 8'h55, 0, 2'b00, 0);
    chk("R7 ctl not taken", out_inj, 0);
    data_pair(8'hA0, 1, "R7 one shot");
    chk("R7 mode cleared", ctl_q, 0);
    data_pair(8'hA1, 0, "R7 after one shot");
  endtask

  task automatic t_jk(input logic [1:0] m, input bit restart);
    sym_a = 5'h0D; sym_b = 5'h1A;
    set_mode(m, 8'd2);
    data_pair(8'hB1, 0, "R8 p1");
    data_pair(8'hB2, 0, "R8 p2");
    step(1, 1, JK, 0, 2'b00, 0);
    chk("R8 jk passes", out_inj, 0);
    data_pair(8'hB3, !restart, "R8 after jk p3");
    data_pair(8'hB4, 0, "R8 after jk p4");
    data_pair(8'hB5, restart, "R8 after jk p5");
  endtask

  task automatic t_conflict;
    sym_a = 5'h1E; sym_b = 5'h01;
    set_mode(2'b01, 8'd3);
    step(1, 0, 8'hC7, 1, 2'b10, 0);
    chk("R10 old mode fires", out_inj, 1);
    chk("R10 write wins", ctl_q, 2);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_ctl = 0; in_byte = 0; thr = 0;
    sym_a = 0; sym_b = 0; ctl_wr = 0; ctl_wdata = 0; rd_stb = 0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_pass();
    t_periodic();
    t_thr0();
    t_oneshot();
    t_jk(2'b11, 1);
    t_jk(2'b10, 0);
    t_conflict();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule